// File: doc/BRIEF.md
# SPI Burst Register Bridge

This block is an SPI target that lets a host processor reach the eight byte-wide registers of a two-channel serial bus controller. One chip-select low period is one burst. The first byte of every burst is a command: its top bit chooses write or read, and its three low bits set an internal register pointer. Each later byte in the same burst writes or reads the register at the pointer, and the pointer then steps to the next register. The register file itself stays outside the bridge. The bridge puts out an address, write data and a single-cycle write strobe. It takes back the read data for whatever address it is presenting.

The SPI pins are brought into the system clock domain through two-stage synchronisers, so the SPI clock must be a good deal slower than the system clock. The bus runs in mode 0: the clock idles low, the host samples MISO on the rising edge, and the bridge changes MISO after the falling edge. Data goes most significant bit first. The controller behind the bridge uses this register order: 0 and 1 are the channel 0 data high and low bytes, 2 and 3 are the channel 1 data high and low bytes, 4 is status, 5 and 6 are the channel 0 and channel 1 control bytes, and 7 is the channel enable byte. The bridge itself treats all eight registers in the same way.

Top module: `spi_burst_bridge`

## Requirements
- R1: While reset is held and after it is released with chip select high, `spi_miso_oe` is 0, `reg_wr` is 0 and `reg_addr` is 0.
- R2: `spi_miso_oe` is 1 while chip select is low and 0 once chip select is high. Chip select high clears the bit count, so the next low period starts a fresh command byte.
- R3: In the command byte, bit 7 = 1 selects a write burst and bit 7 = 0 selects a read burst. Bits [2:0] give the first register, and bits [6:3] have no effect. A read burst never asserts `reg_wr`.
- R4: While the command byte is shifted in, MISO carries the register at the pointer that the previous burst left behind. In the first burst after reset MISO carries 0x00 instead.
- R5: In a write burst, each complete data byte produces exactly one `reg_wr` pulse. During that pulse, `reg_wdata` holds the byte (received MSB first) and `reg_addr` holds the pointer.
- R6: In a read burst, each data byte returns the register at the current pointer, MSB first, in SPI mode 0.
- R7: The pointer advances by one after every complete data byte and wraps from 7 to 0.
- R8: A byte that chip select cuts short is dropped. It causes no write, and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low chip select; one low period is one burst |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for MISO; 0 means the pad is high impedance |
| reg_addr | output | AW | Register pointer, used for both reads and writes |
| reg_rdata | input | DW | Contents of the register at `reg_addr` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | DW | Byte to store on `reg_wr` |

## Verification
The assertions take for granted that the host holds chip select low for at least several system clocks after the last rising SPI clock edge of a burst, so each write strobe falls inside the burst. They also take for granted that every SPI clock phase lasts long enough for the synchronisers to see it. The stimulus keeps each SPI clock phase at eight system clocks. It drives the pins only on falling system-clock edges. It waits half an SPI period after lowering chip select before the first edge, and again after the last edge before raising it.

// File: rtl/spi_burst_bridge.sv
module spi_burst_bridge #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  output logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_rdata,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata
);
  localparam int CW = $clog2(DW);

  logic [2:0]    sclk_q, cs_q;
  logic [1:0]    mosi_q;
  logic [CW-1:0] bit_cnt;
  logic [DW-1:0] rx, tx, wdata;
  logic [AW-1:0] ptr;
  logic          in_data, wdir, seen, step, load;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[1:0], spi_sclk};
      cs_q   <= {cs_q[1:0], spi_cs_n};
      mosi_q <= {mosi_q[0], spi_mosi};
    end

  wire sel       = ~cs_q[1];
  wire cs_fall   = cs_q[2] & ~cs_q[1];
  wire sclk_rise = sclk_q[1] & ~sclk_q[2];
  wire sclk_fall = ~sclk_q[1] & sclk_q[2];
  wire byte_done = sel & sclk_rise & (bit_cnt == CW'(DW-1));
  wire [DW-1:0] rx_byte = {rx[DW-2:0], mosi_q[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_cnt <= '0;
      rx      <= '0;
      tx      <= '0;
      wdata   <= '0;
      ptr     <= '0;
      in_data <= 1'b0;
      wdir    <= 1'b0;
      seen    <= 1'b0;
      step    <= 1'b0;
      load    <= 1'b0;
    end else begin
      step <= 1'b0;
      load <= 1'b0;
      if (!sel) begin
        bit_cnt <= '0;
        in_data <= 1'b0;
      end else if (sclk_rise) begin
        bit_cnt <= byte_done ? '0 : bit_cnt + 1'b1;
        rx      <= rx_byte;
      end
      if (cs_fall) load <= 1'b1;
      if (byte_done) begin
        if (!in_data) begin
          ptr     <= rx_byte[AW-1:0];
          wdir    <= rx_byte[DW-1];
          in_data <= 1'b1;
          seen    <= 1'b1;
          load    <= 1'b1;
        end else begin
          step  <= 1'b1;
          wdata <= rx_byte;
        end
      end
      if (step) begin
        ptr  <= ptr + 1'b1;
        load <= 1'b1;
      end
      if (load)
        tx <= seen ? reg_rdata : '0;
      else if (sel && sclk_fall && bit_cnt != '0)
        tx <= {tx[DW-2:0], 1'b0};
    end

  assign spi_miso    = tx[DW-1];
  assign spi_miso_oe = sel;
  assign reg_addr    = ptr;
  assign reg_wr      = step & wdir;
  assign reg_wdata   = wdata;
endmodule

// File: rtl/spi_burst_bridge_chk.sv
module spi_burst_bridge_chk #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          spi_cs_n,
  input logic          spi_miso_oe,
  input logic [AW-1:0] reg_addr,
  input logic          reg_wr
);
  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> reg_addr == AW'($past(reg_addr) + 1'b1));

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  // R5
  strobe_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> spi_miso_oe);

  // R2
  miso_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
      |-> !spi_miso_oe);
endmodule

bind spi_burst_bridge spi_burst_bridge_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso_oe(spi_miso_oe),
  .reg_addr(reg_addr), .reg_wr(reg_wr));

// File: tb/spi_burst_bridge_bench.sv
module spi_burst_bridge_bench;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] regs [8];
  int wr_count;
  int vectors = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_burst_bridge u_spi_burst_bridge (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata));

  assign reg_rdata = regs[reg_addr];

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) regs[i] <= 8'(8'h3C ^ (i * 37));
      wr_count <= 0;
    end else if (reg_wr) begin
      regs[reg_addr] <= reg_wdata;
      wr_count <= wr_count + 1;
    end

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  task automatic spi_byte(input logic [7:0] tb, output logic [7:0] rb);
    for (int i = 7; i >= 0; i--) begin
      mosi = tb[i];
      repeat (HALF) @(negedge clk);
      rb[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_bits(input int n, input logic [7:0] tb);
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tb[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic burst_begin;
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic burst_end;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 miso_oe", {7'd0, miso_oe}, 8'd0);
    chk("R1 reg_wr", {7'd0, reg_wr}, 8'd0);
    chk("R1 reg_addr", {5'd0, reg_addr}, 8'd0);
  endtask

  task automatic t_first_write;
    logic [7:0] r;
    int base = wr_count;
    burst_begin();
    chk("R2 miso_oe low cs", {7'd0, miso_oe}, 8'd1);
    spi_byte(8'h82, r);
    chk("R4 first command returns zero", r, 8'h00);
    spi_byte(8'h11, r);
    spi_byte(8'h22, r);
    spi_byte(8'h33, r);
    burst_end();
    chk("R2 miso_oe high cs", {7'd0, miso_oe}, 8'd0);
    chk("R5 write count", 8'(wr_count - base), 8'd3);
    chk("R5 reg2", regs[2], 8'h11);
    chk("R5 reg3", regs[3], 8'h22);
    chk("R5 reg4", regs[4], 8'h33);
  endtask

  task automatic t_wrap_write;
    logic [7:0] r;
    burst_begin();
    spi_byte(8'hF6, r);
    chk("R4 command returns reg5", r, regs[5]);
    spi_byte(8'hA6, r);
    spi_byte(8'hA7, r);
    spi_byte(8'hA0, r);
    burst_end();
    chk("R3 R7 reg6", regs[6], 8'hA6);
    chk("R7 reg7", regs[7], 8'hA7);
    chk("R7 wrap reg0", regs[0], 8'hA0);
  endtask

  task automatic t_read;
    logic [7:0] r;
    int base = wr_count;
    burst_begin();
    spi_byte(8'h03, r);
    chk("R4 command returns reg1", r, regs[1]);
    spi_byte(8'hFF, r); chk("R6 read reg3", r, regs[3]);
    spi_byte(8'h00, r); chk("R6 read reg4", r, regs[4]);
    spi_byte(8'h5A, r); chk("R6 read reg5", r, regs[5]);
    burst_end();
    chk("R3 read burst no write", 8'(wr_count - base), 8'd0);
  endtask

  task automatic t_read_wrap;
    logic [7:0] r;
    burst_begin();
    spi_byte(8'h06, r);
    chk("R4 command returns reg6", r, regs[6]);
    spi_byte(8'h00, r); chk("R7 read reg6", r, regs[6]);
    spi_byte(8'h00, r); chk("R7 read reg7", r, regs[7]);
    spi_byte(8'h00, r); chk("R7 wrap read reg0", r, regs[0]);
    spi_byte(8'h00, r); chk("R7 read reg1", r, regs[1]);
    burst_end();
  endtask

  task automatic t_partial;
    logic [7:0] r;
    logic [7:0] keep3;
    int base = wr_count;
    keep3 = regs[3];
    burst_begin();
    spi_byte(8'h82, r);
    chk("R4 command returns reg2", r, regs[2]);
    spi_byte(8'h5C, r);
    spi_bits(3, 8'hA0);
    burst_end();
    chk("R8 one write only", 8'(wr_count - base), 8'd1);
    chk("R8 reg2 written", regs[2], 8'h5C);
    chk("R8 reg3 untouched", regs[3], keep3);
    burst_begin();
    spi_byte(8'h00, r);
    chk("R8 pointer kept at 3", r, regs[3]);
    spi_byte(8'h00, r);
    chk("R6 read reg0", r, regs[0]);
    burst_end();
    burst_begin();
    spi_bits(5, 8'hFF);
    burst_end();
    burst_begin();
    spi_byte(8'h07, r);
    chk("R2 R8 fresh command returns reg1", r, regs[1]);
    spi_byte(8'h00, r);
    chk("R2 R8 read reg7", r, regs[7]);
    burst_end();
    chk("R8 no stray writes", 8'(wr_count - base), 8'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_first_write();
    t_wrap_write();
    t_read();
    t_read_wrap();
    t_partial();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule